// File: doc/BRIEF.md
# Display Window Timing Generator

This block runs on the dot clock of a 1024x768 panel and turns raw, active-low horizontal and vertical sync into an active display window. For every dot clock it reports whether the current sample is a visible pixel, together with its column and row inside the active area. It also gives a pulse on the first pixel of each frame and the interlace field of the frame.

Two placement modes are available. In fixed mode the window sits at a programmable number of dot clocks after each horizontal sync fall and a programmable number of lines after each vertical sync fall. In DE-driven mode the window follows an external active-high data-enable, so the back porch may be any length, and the programmed offsets are not used. A horizontal position counter wraps at a programmed line length, so a line with a missing horizontal sync still ends at a known point. Any disagreement between that length and the real sync period sets a sticky error flag. When external configuration is not selected, built-in default values are used.

Top module: `disp_window_gen`

## Requirements
- R1: A sync falling edge is a dot-clock sample at 0 following a sample at 1. Both sync history registers reset to 1. Every output is a register, and after a clock edge it shows the result for the inputs sampled at that edge.
- R2: In fixed mode (`de_mode`=0), a sample is valid horizontally when its position p is in [HS, HS+ACT_W), where position 0 is the sample holding the horizontal sync fall. Then `x` = p-HS.
- R3: In fixed mode, the line index is 0 on the line where the vertical sync fall is sampled. A vertical fall wins over a line start in the same sample. The index then rises by one at each line start and saturates at 2047; at reset it is 2047. Lines in [VS, VS+ACT_H) are valid, with `y` = line-VS. `pixel_valid` needs both the horizontal and the vertical condition.
- R4: With `cfg_ext`=0, the configuration is HS=296, VS=35 and line length 1344, whatever the cfg inputs hold.
- R5: With `cfg_ext`=1, an HS below 64 is used as 64 and a VS below 4 is used as 4.
- R6: If no horizontal sync fall comes, the position after length-1 is 0. That sample is a new line start for both the line index and the DE tracking.
- R7: `len_err` stays 0 until the first horizontal fall after reset. After that, it becomes 1 when a fall lands on a position other than length-1, or when a wrap happens. Only reset clears it.
- R8: In DE mode (`de_mode`=1), a sample is valid when `de_in`=1, dx<ACT_W and dy<ACT_H. Here dx is the number of earlier `de_in`=1 samples in the line, and dy is the number of earlier lines of the frame that had `de_in`=1. Both counts saturate. dy is ACT_H from reset until the first vertical fall. The cfg values have no effect in this mode.
- R9: `frame_start` is 1 exactly on the valid sample with x=0 and y=0.
- R10: `field` takes `field_in` on each vertical sync fall and holds it otherwise (1 = first field, 0 = second). It resets to 1.
- R11: `x` and `y` are 0 whenever `pixel_valid` is 0. During reset, `pixel_valid`, `x`, `y`, `frame_start` and `len_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| de_in | input | 1 | External data enable, active high |
| de_mode | input | 1 | 1: window follows de_in; 0: fixed offsets |
| field_in | input | 1 | Interlace field, 1 = first field |
| cfg_ext | input | 1 | 1: use cfg inputs; 0: built-in defaults |
| cfg_hstart | input | 9 | Dot clocks from horizontal sync fall to first pixel |
| cfg_vstart | input | 11 | Lines from vertical sync fall to first line |
| cfg_hlen | input | 11 | Programmed line length in dot clocks |
| pixel_valid | output | 1 | Current sample is an active pixel |
| x | output | 10 | Column of the active pixel |
| y | output | 10 | Row of the active pixel |
| frame_start | output | 1 | First pixel of the frame |
| field | output | 1 | Latched field |
| len_err | output | 1 | Sticky line-length mismatch |

## Verification
The bench targets several corner cases, each with the fault it would expose:
- Horizontal and vertical falls in the same sample. A design that let the line start win would number every row one too high.
- A line with the horizontal sync missing. A design that did not wrap would keep counting and lose the window of the next lines.
- The offset clamp and the defaults. Wrong handling would shift the window by a few clocks or lines.
- In DE mode, data-enable that runs past the active width, more data-enable lines than the active height, and data-enable before the first vertical fall. Each would show up as extra valid pixels.
- A period mismatch. A late or non-sticky error flag would be caught by comparing the flag on every clock against a behavioural model.

// File: rtl/disp_win_pkg.sv
package disp_win_pkg;
   localparam int HS_W  = 9;
   localparam int CNT_W = 11;

   typedef enum logic {
      WIN_FIXED = 1'b0,
      WIN_DE    = 1'b1
   } win_mode_e;

   typedef struct packed {
      logic [HS_W-1:0]  hstart;
      logic [CNT_W-1:0] vstart;
      logic [CNT_W-1:0] hlen;
   } win_cfg_t;
endpackage

// File: rtl/dw_fall_detect.sv
module dw_fall_detect #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig_n,
   output logic [N-1:0] fall
);
   logic [N-1:0] prev_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q[i] <= 1'b1;
         else        prev_q[i] <= sig_n[i];
      end
      assign fall[i] = prev_q[i] & ~sig_n[i];
   end
endmodule

// File: rtl/dw_line_timer.sv
module dw_line_timer #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hfall,
   input  logic [CNT_W-1:0] hlen,
   output logic [CNT_W-1:0] pos_now,
   output logic             line_start,
   output logic             len_err
);
   logic [CNT_W-1:0] pos_q;
   logic             locked_q;
   logic             err_q;
   logic             at_end;
   logic             wrap;

   assign at_end     = (pos_q == hlen - CNT_W'(1));
   assign wrap       = ~hfall & at_end;
   assign line_start = hfall | wrap;
   assign pos_now    = line_start ? '0 : pos_q + CNT_W'(1);
   assign len_err    = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= '0;
         locked_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         pos_q <= pos_now;
         if (hfall) locked_q <= 1'b1;
         if (locked_q && (wrap || (hfall && !at_end))) err_q <= 1'b1;
      end
   end

   // R6
   pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q != '0) |-> (pos_q == $past(pos_q) + CNT_W'(1)));

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: rtl/dw_frame_timer.sv
module dw_frame_timer #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vfall,
   input  logic             line_start,
   output logic [CNT_W-1:0] line_now
);
   logic [CNT_W-1:0] line_q;

   always_comb begin
      if (vfall)                        line_now = '0;
      else if (line_start && !(&line_q)) line_now = line_q + CNT_W'(1);
      else                              line_now = line_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= '1;
      else        line_q <= line_now;
   end

   // R3
   line_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_q != '0) |-> (line_q >= $past(line_q)));
endmodule

// File: rtl/dw_de_tracker.sv
module dw_de_tracker #(
   parameter int ACT_W = 1024,
   parameter int ACT_H = 768,
   parameter int DXW   = 11,
   parameter int DYW   = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           line_start,
   input  logic           vfall,
   input  logic           de,
   output logic [DXW-1:0] dx_now,
   output logic [DYW-1:0] dy_now
);
   logic [DXW-1:0] dx_q;
   logic [DYW-1:0] dy_q;
   logic           had_q;
   logic           had_base;

   assign dx_now   = line_start ? '0 : dx_q;
   assign had_base = (line_start | vfall) ? 1'b0 : had_q;

   always_comb begin
      if (vfall) dy_now = '0;
      else if (line_start && had_q && dy_q != DYW'(ACT_H)) dy_now = dy_q + DYW'(1);
      else dy_now = dy_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dx_q  <= '0;
         dy_q  <= DYW'(ACT_H);
         had_q <= 1'b0;
      end else begin
         dx_q  <= (de && dx_now != DXW'(ACT_W)) ? dx_now + DXW'(1) : dx_now;
         dy_q  <= dy_now;
         had_q <= had_base | de;
      end
   end

   // R8
   dx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dx_q <= DXW'(ACT_W));
endmodule

// File: rtl/disp_window_gen.sv
module disp_window_gen
   import disp_win_pkg::*;
#(
   parameter int ACT_W       = 1024,
   parameter int ACT_H       = 768,
   parameter int XO_W        = 10,
   parameter int YO_W        = 10,
   parameter int DEF_HSTART  = 296,
   parameter int DEF_VSTART  = 35,
   parameter int DEF_HLEN    = 1344,
   parameter int MIN_HSTART  = 64,
   parameter int MIN_VSTART  = 4,
   parameter bit CLAMP_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_n,
   input  logic             vsync_n,
   input  logic             de_in,
   input  logic             de_mode,
   input  logic             field_in,
   input  logic             cfg_ext,
   input  logic [HS_W-1:0]  cfg_hstart,
   input  logic [CNT_W-1:0] cfg_vstart,
   input  logic [CNT_W-1:0] cfg_hlen,
   output logic             pixel_valid,
   output logic [XO_W-1:0]  x,
   output logic [YO_W-1:0]  y,
   output logic             frame_start,
   output logic             field,
   output logic             len_err
);
   localparam int DXW = $clog2(ACT_W + 1);
   localparam int DYW = $clog2(ACT_H + 1);

   initial begin
      assert (ACT_W <= 2**XO_W) else $error("ACT_W exceeds x width");
      assert (ACT_H <= 2**YO_W) else $error("ACT_H exceeds y width");
      assert (XO_W <= CNT_W && YO_W <= CNT_W) else $error("coordinate width too large");
      assert (DEF_HLEN < 2**CNT_W && DEF_VSTART < 2**CNT_W) else $error("default too large");
      assert (DEF_HSTART < 2**HS_W && MIN_HSTART < 2**HS_W) else $error("hstart too large");
   end

   // configuration selection
   win_cfg_t  cfg_lim;
   win_cfg_t  cfg_eff;
   win_mode_e mode;

   if (CLAMP_EN) begin : g_clamp
      assign cfg_lim.hstart = (cfg_hstart < HS_W'(MIN_HSTART)) ? HS_W'(MIN_HSTART) : cfg_hstart;
      assign cfg_lim.vstart = (cfg_vstart < CNT_W'(MIN_VSTART)) ? CNT_W'(MIN_VSTART) : cfg_vstart;
   end else begin : g_raw
      assign cfg_lim.hstart = cfg_hstart;
      assign cfg_lim.vstart = cfg_vstart;
   end
   assign cfg_lim.hlen = cfg_hlen;

   assign cfg_eff = cfg_ext ? cfg_lim :
                    '{hstart: HS_W'(DEF_HSTART), vstart: CNT_W'(DEF_VSTART), hlen: CNT_W'(DEF_HLEN)};
   assign mode    = de_mode ? WIN_DE : WIN_FIXED;

   // sync edges
   logic [1:0] falls;
   logic       hfall;
   logic       vfall;

   dw_fall_detect #(.N(2)) u_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_n ({vsync_n, hsync_n}),
      .fall  (falls)
   );
   assign hfall = falls[0];
   assign vfall = falls[1];

   // counters
   logic [CNT_W-1:0] pos_now;
   logic [CNT_W-1:0] line_now;
   logic             line_start;
   logic             err_w;

   dw_line_timer #(.CNT_W(CNT_W)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .hfall      (hfall),
      .hlen       (cfg_eff.hlen),
      .pos_now    (pos_now),
      .line_start (line_start),
      .len_err    (err_w)
   );

   dw_frame_timer #(.CNT_W(CNT_W)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .vfall      (vfall),
      .line_start (line_start),
      .line_now   (line_now)
   );

   logic [DXW-1:0] dx_now;
   logic [DYW-1:0] dy_now;

   dw_de_tracker #(.ACT_W(ACT_W), .ACT_H(ACT_H), .DXW(DXW), .DYW(DYW)) u_de (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .vfall      (vfall),
      .de         (de_in),
      .dx_now     (dx_now),
      .dy_now     (dy_now)
   );

   // fixed-mode window
   logic [CNT_W:0] hpos_ext, vpos_ext, hs_ext, vs_ext, hdiff, vdiff;
   logic           fix_h_in, fix_v_in, fix_ok, de_ok;

   assign hpos_ext = {1'b0, pos_now};
   assign vpos_ext = {1'b0, line_now};
   assign hs_ext   = (CNT_W + 1)'(cfg_eff.hstart);
   assign vs_ext   = {1'b0, cfg_eff.vstart};
   assign hdiff    = hpos_ext - hs_ext;
   assign vdiff    = vpos_ext - vs_ext;
   assign fix_h_in = (hpos_ext >= hs_ext) && (hpos_ext < hs_ext + (CNT_W + 1)'(ACT_W));
   assign fix_v_in = (vpos_ext >= vs_ext) && (vpos_ext < vs_ext + (CNT_W + 1)'(ACT_H));
   assign fix_ok   = fix_h_in & fix_v_in;
   assign de_ok    = de_in && (dx_now < DXW'(ACT_W)) && (dy_now < DYW'(ACT_H));

   // output selection
   logic            valid_nx;
   logic [XO_W-1:0] x_nx;
   logic [YO_W-1:0] y_nx;

   always_comb begin
      valid_nx = 1'b0;
      x_nx     = '0;
      y_nx     = '0;
      unique case (mode)
         WIN_DE: begin
            valid_nx = de_ok;
            if (de_ok) begin
               x_nx = XO_W'(dx_now);
               y_nx = YO_W'(dy_now);
            end
         end
         default: begin
            valid_nx = fix_ok;
            if (fix_ok) begin
               x_nx = hdiff[XO_W-1:0];
               y_nx = vdiff[YO_W-1:0];
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pixel_valid <= 1'b0;
         x           <= '0;
         y           <= '0;
         frame_start <= 1'b0;
         field       <= 1'b1;
      end else begin
         pixel_valid <= valid_nx;
         x           <= x_nx;
         y           <= y_nx;
         frame_start <= valid_nx && (x_nx == '0) && (y_nx == '0);
         if (vfall) field <= field_in;
      end
   end

   assign len_err = err_w;

   // R2
   x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pixel_valid && $past(pixel_valid) && x != '0) |-> (x == $past(x) + XO_W'(1)));

   // R10
   field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vfall |=> (field == $past(field)));

   // R11
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pixel_valid |-> (x == '0 && y == '0 && !frame_start));
endmodule

// File: tb/disp_window_gen_test.sv
`timescale 1ns/1ps
module disp_window_gen_test;
   localparam int W = 16;
   localparam int H = 6;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        hsync_n = 1'b1, vsync_n = 1'b1, de_in = 1'b0, de_mode = 1'b0;
   logic        field_in = 1'b1, cfg_ext = 1'b0;
   logic [8:0]  cfg_hstart = '0;
   logic [10:0] cfg_vstart = '0, cfg_hlen = '0;
   logic        pixel_valid, frame_start, field, len_err;
   logic [9:0]  x, y;

   disp_window_gen #(.ACT_W(W), .ACT_H(H)) uut (
      .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
      .de_in(de_in), .de_mode(de_mode), .field_in(field_in), .cfg_ext(cfg_ext),
      .cfg_hstart(cfg_hstart), .cfg_vstart(cfg_vstart), .cfg_hlen(cfg_hlen),
      .pixel_valid(pixel_valid), .x(x), .y(y), .frame_start(frame_start),
      .field(field), .len_err(len_err)
   );

   integer checks = 0, failures = 0;
   string  tag = "R11";
   bit     done = 1'b0;

   // behavioural reference state
   integer mh, mv, mdx, mdy, mhad, mlock, merr, mfld, phs, pvs;
   integer e_v, e_x, e_y, e_fs;

   always @(posedge clk) begin
      integer hd, vd, hl, p, lv, dxb, dyb, hadb, hf, vf, ls, wrap, ex, ey;
      if (!rst_n) begin
         mh = 0; mv = 2047; mdx = 0; mdy = H; mhad = 0; mlock = 0; merr = 0;
         mfld = 1; phs = 1; pvs = 1; e_v = 0; e_x = 0; e_y = 0; e_fs = 0;
      end else begin
         hf = (phs == 1 && hsync_n == 1'b0) ? 1 : 0;   // R1
         vf = (pvs == 1 && vsync_n == 1'b0) ? 1 : 0;
         if (cfg_ext) begin                             // R4 R5
            hd = (cfg_hstart < 64) ? 64 : cfg_hstart;
            vd = (cfg_vstart < 4) ? 4 : cfg_vstart;
            hl = cfg_hlen;
         end else begin
            hd = 296; vd = 35; hl = 1344;
         end
         wrap = (!hf && mh == hl - 1) ? 1 : 0;          // R6
         if (mlock && (wrap || (hf && mh != hl - 1))) merr = 1;  // R7
         if (hf) mlock = 1;
         ls = hf | wrap;
         p  = ls ? 0 : (mh + 1) % 2048;
         lv = vf ? 0 : (ls ? ((mv < 2047) ? mv + 1 : 2047) : mv);  // R3
         dxb  = ls ? 0 : mdx;                           // R8
         dyb  = vf ? 0 : ((ls && mhad && mdy < H) ? mdy + 1 : mdy);
         hadb = (ls || vf) ? 0 : mhad;
         if (de_mode) begin
            e_v = (de_in && dxb < W && dyb < H) ? 1 : 0; ex = dxb; ey = dyb;
         end else begin                                 // R2
            e_v = (p >= hd && p < hd + W && lv >= vd && lv < vd + H) ? 1 : 0;
            ex = p - hd; ey = lv - vd;
         end
         e_x  = e_v ? ex : 0;                           // R11
         e_y  = e_v ? ey : 0;
         e_fs = (e_v && ex == 0 && ey == 0) ? 1 : 0;    // R9
         mdx  = dxb + ((de_in && dxb < W) ? 1 : 0);
         mdy  = dyb;
         mhad = hadb | (de_in ? 1 : 0);
         if (vf) mfld = field_in;                       // R10
         mh = p; mv = lv; phs = hsync_n; pvs = vsync_n;
      end
      #1;
      if (!done) begin
         checks++;
         if (pixel_valid !== e_v[0] || x !== e_x[9:0] || y !== e_y[9:0] ||
             frame_start !== e_fs[0] || field !== mfld[0] || len_err !== merr[0]) begin
            failures++;
            if (failures <= 20)
               $display("FAIL %s t=%0t actual v=%0b x=%0d y=%0d fs=%0b fld=%0b err=%0b expected v=%0d x=%0d y=%0d fs=%0d fld=%0d err=%0d",
                        tag, $time, pixel_valid, x, y, frame_start, field, len_err,
                        e_v, e_x, e_y, e_fs, mfld, merr);
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; hsync_n = 1'b1; vsync_n = 1'b1; de_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drive_line(input int period, input bit hs_en, input bit vs_low,
                             input int ds, input int dl);
      for (int c = 0; c < period; c++) begin
         @(negedge clk);
         hsync_n = !(hs_en && c < 8);
         vsync_n = !vs_low;
         de_in   = (c >= ds && c < ds + dl);
      end
   endtask

   task automatic drive_frame(input int period, input int nlines);
      for (int l = 0; l < nlines; l++) drive_line(period, 1'b1, l < 3, 0, 0);
   endtask

   initial begin
      // R11: reset state
      tag = "R11";
      do_reset();
      repeat (4) @(negedge clk);

      // R4: defaults, cfg inputs hold other values; R3 R1 simultaneous falls
      tag = "R4 R3 R1";
      cfg_ext = 1'b0; cfg_hstart = 9'd100; cfg_vstart = 11'd8; cfg_hlen = 11'd100;
      drive_frame(1344, 42);

      // R2 R3 R9 R10: programmed offsets, two fields
      tag = "R2 R3 R9 R10";
      cfg_ext = 1'b1; cfg_hstart = 9'd70; cfg_vstart = 11'd5; cfg_hlen = 11'd100;
      do_reset();
      field_in = 1'b1; drive_frame(100, 12);
      field_in = 1'b0; drive_frame(100, 12);
      field_in = 1'b1;

      // R5: clamp of small offsets
      tag = "R5";
      cfg_hstart = 9'd10; cfg_vstart = 11'd1;
      do_reset();
      drive_frame(100, 11);

      // R6 R7: missing hsync line, wrap raises error
      tag = "R6 R7";
      cfg_hstart = 9'd70; cfg_vstart = 11'd4;
      do_reset();
      for (int l = 0; l < 3; l++) drive_line(100, 1'b1, l < 3, 0, 0);
      drive_line(250, 1'b0, 1'b0, 0, 0);
      for (int l = 0; l < 8; l++) drive_line(100, 1'b1, 1'b0, 0, 0);

      // R7: period shorter than programmed length
      tag = "R7";
      do_reset();
      for (int l = 0; l < 5; l++) drive_line(90, 1'b1, l < 2, 0, 0);

      // R8: DE mode, offsets ignored, width and height caps, DE before vsync
      tag = "R8";
      de_mode = 1'b1; cfg_hstart = 9'd200; cfg_vstart = 11'd50;
      do_reset();
      drive_line(100, 1'b1, 1'b0, 20, 10);
      drive_line(100, 1'b1, 1'b1, 20, 10);
      drive_line(100, 1'b1, 1'b1, 0, 0);
      drive_line(100, 1'b1, 1'b1, 15, 20);
      for (int l = 0; l < 8; l++) drive_line(100, 1'b1, 1'b0, 30 + l, 12);
      tag = "R8 R10";
      field_in = 1'b0;
      for (int l = 0; l < 4; l++) drive_line(100, 1'b1, l < 2, 40, 5);
      de_mode = 1'b0;
      repeat (5) @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule